// File: doc/BRIEF.md
# LIN Bus Wake-Up Character Transmitter

This block drives the transmit line of a LIN node so that a sleeping cluster sees a wake-up request. On a one-cycle start command it sends one fixed character in ordinary asynchronous framing: a start bit, eight data bits least significant first, then a recessive stop bit. Each bit lasts from one baud tick to the next. The baud tick comes from a bit-rate generator outside the block.

A type select input picks the character. The newer-revision pattern is 0xF0. Its start bit and four low data bits make a dominant run of five bit times. At any bit rate from 1 to 20 kbit/s, that run falls inside the 250 µs to 5 ms wake-up window. The older-revision pattern is 0x80, which makes a dominant run of eight bit times. When the stop bit ends, a sticky completion flag rises. It stays high until a clear command removes it.

Top module: `lin_wakeup_tx`

## Requirements
- R1: After reset, and whenever no character is in flight (including after the stop bit), `txd_o` is 1 (recessive) and the frame ends with `txd_o` back at 1.
- R2: With `type_sel_i` = 0 when the start is accepted, the frame on `txd_o` is start bit 0, then the data byte 0xF0 least significant bit first, then one stop bit 1.
- R3: With `type_sel_i` = 1 when the start is accepted, the frame carries the data byte 0x80 in the same framing.
- R4: The dominant run at the head of the frame lasts exactly 5 bit times for type 0 and exactly 8 bit times for type 1.
- R5: `txd_o` goes to the start bit in the cycle after an accepted start. After that it changes only in the cycle after a `baud_tick_i` pulse, and it holds its value across cycles without a tick.
- R6: `done_o` rises in the same cycle that the stop bit ends (the cycle after the tenth tick). It is 0 while the frame is in flight, and it stays 1 until it is cleared.
- R7: A `clr_status_i` pulse drops `done_o` to 0 in the next cycle. If a clear comes in the same cycle as frame completion, the completion wins and `done_o` stays 1.
- R8: A start pulse while a frame is in flight is ignored. The running frame continues unchanged and no second frame follows.
- R9: `type_sel_i` is sampled only when the start is accepted. Changing it mid-frame has no effect on the bits sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | One-cycle wake-up start command |
| type_sel_i | input | 1 | 0: five-bit dominant pattern, 1: eight-bit dominant pattern |
| baud_tick_i | input | 1 | One-cycle pulse marking each bit boundary |
| clr_status_i | input | 1 | One-cycle command to clear the completion flag |
| txd_o | output | 1 | Serial transmit line, idle high |
| done_o | output | 1 | Sticky transfer-complete flag |

## Verification
- **Start bit:** it is due on `txd_o` one clock after the start is accepted.
- **Later bits:** each one is due one clock after the baud tick that ends the previous bit.
- **Completion flag:** it rises on the same edge that ends the stop bit, and a clear acts one clock after it is issued.
- **How the bench keeps to this:** it changes every input just after a falling edge and reads the outputs at the following falling edge, so each reading sees exactly one rising edge after its stimulus. Extra tick-free clocks between bits let the bench confirm that the line holds its value.

// File: rtl/lin_wkup_pkg.sv
// Package: shared constants and the wake-up pattern lookup for the LIN
// wake-up transmitter. Assumes an 8-bit character and two pattern types.
package lin_wkup_pkg;

    localparam int WK_CHAR_W = 8;

    typedef enum logic {
        WK_FIVE_DOM  = 1'b0,
        WK_EIGHT_DOM = 1'b1
    } wk_type_e;

    // Returns the wake-up byte for a pattern type.
    function automatic logic [WK_CHAR_W-1:0] wake_char(input wk_type_e kind);
        logic [WK_CHAR_W-1:0] ch;
        case (kind)
            WK_EIGHT_DOM: ch = 8'h80;
            default:      ch = 8'hF0;
        endcase
        return ch;
    endfunction

endpackage

// File: rtl/wkup_launch.sv
// Launch gate: accepts a start command only while no frame is in flight,
// and samples the type select at that moment to pick the character.
// Assumes start_i is a one-cycle pulse.
module wkup_launch
    import lin_wkup_pkg::*;
(
    input  logic                 start_i,
    input  logic                 type_sel_i,
    input  logic                 busy_i,
    output logic                 load_o,
    output logic [WK_CHAR_W-1:0] char_o
);

    // Gate the start and choose the pattern byte.
    always_comb begin
        load_o = start_i && !busy_i;
        char_o = wake_char(wk_type_e'(type_sel_i));
    end

endmodule

// File: rtl/wkup_serializer.sv
// Frame serializer: loads start bit, data and stop bits into a shift
// register and shifts one bit out per baud tick, LSB first. The line
// bit is the register's low bit, so it is glitch-free. It idles high
// because the register fills with ones. Assumes baud_tick_i is a
// one-cycle pulse.
module wkup_serializer #(
    parameter int CHAR_W    = 8,
    parameter int STOP_BITS = 1,
    localparam int FRAME_W  = CHAR_W + 1 + STOP_BITS,
    localparam int CNT_W    = $clog2(FRAME_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [CHAR_W-1:0] char_i,
    input  logic              baud_tick_i,
    output logic              txd_o,
    output logic              busy_o,
    output logic              finish_o,
    output logic [CNT_W-1:0]  bit_idx_o
);

    localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(FRAME_W - 1);

    logic [FRAME_W-1:0] shreg_q;
    logic [CNT_W-1:0]   idx_q;
    logic               busy_q;
    logic               last_bit;

    // Flag the tick that ends the final stop bit.
    always_comb begin
        last_bit = (idx_q == LAST_IDX);
        finish_o = busy_q && baud_tick_i && last_bit;
    end

    // Load a frame on launch, shift one bit per tick while busy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg_q <= '1;
            idx_q   <= '0;
            busy_q  <= 1'b0;
        end else if (load_i) begin
            shreg_q <= {{STOP_BITS{1'b1}}, char_i, 1'b0};
            idx_q   <= '0;
            busy_q  <= 1'b1;
        end else if (busy_q && baud_tick_i) begin
            shreg_q <= {1'b1, shreg_q[FRAME_W-1:1]};
            if (last_bit) begin
                idx_q  <= '0;
                busy_q <= 1'b0;
            end else begin
                idx_q <= idx_q + 1'b1;
            end
        end
    end

    assign txd_o     = shreg_q[0];
    assign busy_o    = busy_q;
    assign bit_idx_o = idx_q;

endmodule

// File: rtl/wkup_status_flag.sv
// Sticky completion flag: set by frame completion, cleared by command.
// When both arrive in the same cycle, the set wins.
module wkup_status_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic flag_o
);

    logic flag_q;

    // Hold the flag; set has priority over clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_q <= 1'b0;
        end else if (set_i) begin
            flag_q <= 1'b1;
        end else if (clr_i) begin
            flag_q <= 1'b0;
        end
    end

    assign flag_o = flag_q;

endmodule

// File: rtl/lin_wakeup_tx.sv
// LIN wake-up transmitter top: on an accepted start it sends one fixed
// wake-up character on TXD at the baud-tick rate, then raises a sticky
// completion flag. Assumes an external baud-tick source and one-cycle
// command pulses. Synchronous active-low reset.
module lin_wakeup_tx
    import lin_wkup_pkg::*;
#(
    parameter int STOP_BITS = 1,
    localparam int FRAME_W  = WK_CHAR_W + 1 + STOP_BITS,
    localparam int CNT_W    = $clog2(FRAME_W)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    input  logic type_sel_i,
    input  logic baud_tick_i,
    input  logic clr_status_i,
    output logic txd_o,
    output logic done_o
);

    logic                 busy_w;
    logic                 load_w;
    logic                 finish_w;
    logic [WK_CHAR_W-1:0] char_w;
    logic [CNT_W-1:0]     bit_idx_w;

    wkup_launch i_launch (
        .start_i    (start_i),
        .type_sel_i (type_sel_i),
        .busy_i     (busy_w),
        .load_o     (load_w),
        .char_o     (char_w)
    );

    wkup_serializer #(
        .CHAR_W    (WK_CHAR_W),
        .STOP_BITS (STOP_BITS)
    ) i_ser (
        .clk         (clk),
        .rst_n       (rst_n),
        .load_i      (load_w),
        .char_i      (char_w),
        .baud_tick_i (baud_tick_i),
        .txd_o       (txd_o),
        .busy_o      (busy_w),
        .finish_o    (finish_w),
        .bit_idx_o   (bit_idx_w)
    );

    wkup_status_flag i_flag (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (finish_w),
        .clr_i  (clr_status_i),
        .flag_o (done_o)
    );

endmodule

// File: rtl/lin_wakeup_tx_chk.sv
// Checker for the LIN wake-up transmitter, bound to the top module.
// Relates the port behaviour to the serializer's busy, finish and bit index.
module lin_wakeup_tx_chk #(
    parameter int CNT_W = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start_i,
    input logic             baud_tick_i,
    input logic             clr_status_i,
    input logic             txd_o,
    input logic             done_o,
    input logic             busy,
    input logic             finish,
    input logic [CNT_W-1:0] bit_idx
);

    // R1: line is recessive whenever no frame is in flight.
    p_idle_high_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> txd_o);

    // R2: an accepted start puts the dominant start bit on the line.
    p_start_bit_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy) |=> !txd_o);

    // R5: without a tick or a start, the line holds its value.
    p_hold_no_tick_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!baud_tick_i && !start_i) |=> $stable(txd_o));

    // R6: the completion flag stays set unless cleared.
    p_done_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !clr_status_i) |=> done_o);

    // R7: completion wins over a same-cycle clear.
    p_set_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
        finish |=> done_o);

    // R7: a clear without completion drops the flag.
    p_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_status_i && !finish) |=> !done_o);

    // R8: a start during a frame does not restart the bit position.
    p_ignore_start_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && busy && !baud_tick_i) |=> $stable(bit_idx));

endmodule

bind lin_wakeup_tx lin_wakeup_tx_chk #(
    .CNT_W (CNT_W)
) i_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_i      (start_i),
    .baud_tick_i  (baud_tick_i),
    .clr_status_i (clr_status_i),
    .txd_o        (txd_o),
    .done_o       (done_o),
    .busy         (busy_w),
    .finish       (finish_w),
    .bit_idx      (bit_idx_w)
);

// File: tb/test_lin_wakeup_tx.sv
module test_lin_wakeup_tx;

    localparam int CLK_PERIOD = 10;
    localparam int FRAME_N    = 10;
    localparam int IDLE_GAP   = 2;
    localparam int NVEC       = 5;

    // Vector: {flip_type_mid, restart_mid, type_sel, expected byte}
    localparam logic [10:0] VEC [NVEC] = '{
        {1'b0, 1'b0, 1'b0, 8'hF0},
        {1'b0, 1'b0, 1'b1, 8'h80},
        {1'b0, 1'b1, 1'b0, 8'hF0},
        {1'b1, 1'b0, 1'b1, 8'h80},
        {1'b1, 1'b1, 1'b0, 8'hF0}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start_i = 1'b0;
    logic type_sel_i = 1'b0;
    logic baud_tick_i = 1'b0;
    logic clr_status_i = 1'b0;
    logic txd_o;
    logic done_o;

    int chk_cnt = 0;
    int fail_cnt = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    lin_wakeup_tx i_lin_wakeup_tx (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_i      (start_i),
        .type_sel_i   (type_sel_i),
        .baud_tick_i  (baud_tick_i),
        .clr_status_i (clr_status_i),
        .txd_o        (txd_o),
        .done_o       (done_o)
    );

    task automatic chk(input logic act, input logic exp, input string req);
        chk_cnt++;
        if (act !== exp) begin
            fail_cnt++;
            $display("FAIL %s actual=%0b expected=%0b", req, act, exp);
        end
    endtask

    task automatic chk_int(input int act, input int exp, input string req);
        chk_cnt++;
        if (act != exp) begin
            fail_cnt++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic pulse_start();
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
    endtask

    task automatic pulse_tick();
        baud_tick_i = 1'b1;
        @(negedge clk);
        baud_tick_i = 1'b0;
    endtask

    task automatic pulse_clr();
        clr_status_i = 1'b1;
        @(negedge clk);
        clr_status_i = 1'b0;
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        #(CLK_PERIOD * 100000);
        fail_cnt++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", chk_cnt, fail_cnt);
        $finish;
    end

    initial begin
        // Reset state (R1, R6)
        repeat (3) @(negedge clk);
        chk(txd_o, 1'b1, "R1 reset txd");
        chk(done_o, 1'b0, "R6 reset done");
        rst_n = 1'b1;
        @(negedge clk);
        chk(txd_o, 1'b1, "R1 idle txd");

        // Vector walk
        for (int v = 0; v < NVEC; v++) begin
            logic [FRAME_N-1:0] frame;
            int run;
            bit in_run;
            frame = {1'b1, VEC[v][7:0], 1'b0};
            pulse_clr();
            chk(done_o, 1'b0, "R7 clear before frame");
            type_sel_i = VEC[v][8];
            pulse_start();
            run = 0;
            in_run = 1'b1;
            for (int k = 0; k < FRAME_N; k++) begin
                chk(txd_o, frame[k], VEC[v][8] ? "R3 frame bit" : "R2 frame bit");
                if (in_run && txd_o == 1'b0) run++;
                else in_run = 1'b0;
                chk(done_o, 1'b0, "R6 done low in flight");
                if (k == 3 && VEC[v][9]) pulse_start();
                if (k == 3 && VEC[v][10]) type_sel_i = ~type_sel_i;
                repeat (IDLE_GAP) @(negedge clk);
                chk(txd_o, frame[k], "R5 hold without tick");
                if (k == 3 && (VEC[v][9] || VEC[v][10])) begin
                    chk(txd_o, frame[k], VEC[v][9] ? "R8 restart ignored" : "R9 type held");
                end
                pulse_tick();
            end
            chk(txd_o, 1'b1, "R1 line high after stop");
            chk(done_o, 1'b1, "R6 done at frame end");
            chk_int(run, VEC[v][8] ? 8 : 5, "R4 dominant run");
            repeat (5) @(negedge clk);
            chk(done_o, 1'b1, "R6 done sticky");
            chk(txd_o, 1'b1, "R8 no second frame");
        end

        // R7: clear lifts flag one cycle later
        pulse_clr();
        chk(done_o, 1'b0, "R7 clear");
        pulse_clr();
        chk(done_o, 1'b0, "R7 clear when already low");

        // R7: set wins over same-cycle clear
        type_sel_i = 1'b0;
        pulse_start();
        for (int k = 0; k < FRAME_N - 1; k++) pulse_tick();
        chk(txd_o, 1'b1, "R2 stop bit");
        chk(done_o, 1'b0, "R6 not done during stop bit");
        baud_tick_i = 1'b1;
        clr_status_i = 1'b1;
        @(negedge clk);
        baud_tick_i = 1'b0;
        clr_status_i = 1'b0;
        chk(done_o, 1'b1, "R7 set wins over clear");

        // R1: reset in mid-frame returns the line high and the flag low
        type_sel_i = 1'b1;
        pulse_start();
        pulse_tick();
        chk(txd_o, 1'b0, "R3 dominant mid-frame");
        rst_n = 1'b0;
        @(negedge clk);
        chk(txd_o, 1'b1, "R1 reset mid-frame txd");
        chk(done_o, 1'b0, "R6 reset clears done");
        rst_n = 1'b1;
        pulse_tick();
        chk(txd_o, 1'b1, "R5 tick while idle no effect");

        $display("TB_RESULT checks=%0d failures=%0d", chk_cnt, fail_cnt);
        $finish;
    end

endmodule